// File: doc/BRIEF.md
# Zero-Suppressed Token Readout Controller

This block reads out a 64 by 64 matrix of hit-recording pixels and sends only the pixels that saw a hit. Each pixel stores a hit flag, a 5-bit arrival code and an 8-bit amplitude word. A hit is written through a capture port that names the pixel's row and column. The arrival code is the bitwise inverse of the Gray code of a free-running counter. That counter advances on each rising edge of a separate stamp clock, which is synchronised into the block clock.

A frame starts when a read token is injected at pixel (0,0). The token passes through empty pixels in the same cycle and stops at the first pixel holding a hit. That pixel's record is placed on a valid/ready output. The token stays at that pixel until the record is accepted. The pixel's hit is then cleared and the token moves on.

Row and column addresses of the pixel holding the token come from the scan logic, not from the pixel. Once the token leaves the last pixel, an end-of-frame pulse is raised. Two test modes exist: one reads every pixel whether or not it holds a hit, and one reads only pixel (0,0).

Top module: `sparse_readout`

## Requirements
- R1: After reset, rec_valid, frame_end and busy are low, and the arrival code is 5'b11111 (counter at 0).
- R2: The arrival code equals ~(n ^ (n >> 1)) for a 5-bit counter n. The counter increments once per rising edge of stamp_clk, three clk cycles after the edge is sampled, and wraps from 31 to 0. Successive codes differ in exactly one bit.
- R3: A cycle with hit_stb high and the pixel empty sets that pixel's hit and stores the current arrival code and hit_amp. A strobe to a pixel that already holds a hit is ignored until that pixel has been read.
- R4: In sparse mode (rd_mode 0, and rd_mode 3 treated the same), a frame yields one record per hit pixel and none for empty pixels. Records come in ascending row order, then ascending column order. Reading a pixel clears its hit. The record layout is row in rec_data[24:19], column in [18:13], arrival code in [12:8] and amplitude in [7:0].
- R5: While rec_valid is high and rec_ready is low, rec_valid stays high and rec_data stays stable. The token does not advance and no new record is loaded until the current one is accepted.
- R6: tok_inject sampled while idle starts a frame, and busy is high from the next cycle. With no hits present, no record is produced and frame_end is high one cycle later.
- R7: frame_end is a one-cycle pulse, raised the cycle after the token leaves the last pixel. That is the edge at which the last record is accepted, or the edge after the scan finds nothing left. busy falls at the same edge.
- R8: In rd_mode 1, every one of the 4096 pixels yields one record in scan order. A pixel without a hit reports code 0 and amplitude 0. All hits are cleared by the frame.
- R9: In rd_mode 2, only pixel (0,0) is read, whether or not it holds a hit, and then the frame ends. Hits at other pixels are kept.
- R10: A strobe to a pixel in the same cycle that its record is loaded is not lost. The new hit is stored with its own code and amplitude and is read in the next frame.
- R11: tok_inject while a frame is running is ignored and does not start a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stamp_clk | input | 1 | Stamp clock; each rising edge advances the arrival counter |
| hit_stb | input | 1 | Capture strobe for one pixel hit |
| hit_row | input | 6 | Row of the pixel being hit |
| hit_col | input | 6 | Column of the pixel being hit |
| hit_amp | input | 8 | Digitised amplitude of the hit |
| rd_mode | input | 2 | Frame mode: 0/3 sparse, 1 read all pixels, 2 read pixel (0,0) only |
| tok_inject | input | 1 | Injects the read token at pixel (0,0) when idle |
| rec_ready | input | 1 | Downstream accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_data | output | 25 | Record {row, column, arrival code, amplitude} |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | A frame is in progress |

## Verification
Hit capture and readout can both touch the same pixel in one cycle: the token may be loading that pixel's record and clearing its hit while a new strobe for it arrives. The bench provokes this by injecting the token with a single stored hit and driving a strobe for that pixel, with a different amplitude, in the cycle the scan reaches it. It then checks that the current frame reports the old amplitude and that the following frame reports the new amplitude with its own code. A second overlap, injection while a frame is running, is provoked during a full-matrix frame and judged by a single end pulse and an exact record count.

// File: rtl/sparse_ro_pkg.sv
`timescale 1ns/1ps
package sparse_ro_pkg;

  // Frame read modes selected at token injection.
  typedef enum logic [1:0] {
    RD_SPARSE     = 2'd0,
    RD_ALL        = 2'd1,
    RD_PIX0       = 2'd2,
    RD_SPARSE_ALT = 2'd3
  } rd_mode_e;

  // Token walker state.
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;

endpackage

// File: rtl/sparse_stamp_gen.sv
`timescale 1ns/1ps
module sparse_stamp_gen #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stamp_clk,
  output logic [TS_W-1:0] ts_code
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q, sync_d;
  logic [TS_W-1:0]   cnt_q, cnt_d;
  logic              stamp_rise;

  always_comb begin
    sync_d     = {sync_q[SYNC_W-2:0], stamp_clk};
    stamp_rise = sync_q[1] & ~sync_q[2];
    cnt_d      = cnt_q;
    if (stamp_rise) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  // Inverted Gray encoding of the running count.
  assign ts_code = ~(cnt_q ^ (cnt_q >> 1));

  // R2: each change of the code flips a single bit
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_code != $past(ts_code)) |-> ($countones(ts_code ^ $past(ts_code)) == 1));

endmodule

// File: rtl/sparse_pixel_store.sv
`timescale 1ns/1ps
module sparse_pixel_store #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int TS_W  = 5,
  parameter int AMP_W = 8,
  parameter int RA_W  = 6,
  parameter int CA_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [RA_W-1:0]            cap_row,
  input  logic [CA_W-1:0]            cap_col,
  input  logic [AMP_W-1:0]           cap_amp,
  input  logic [TS_W-1:0]            ts_code,
  input  logic                       clr_en,
  input  logic [RA_W-1:0]            clr_row,
  input  logic [CA_W-1:0]            clr_col,
  input  logic [RA_W-1:0]            rd_row,
  input  logic [CA_W-1:0]            rd_col,
  output logic                       rd_hit,
  output logic [TS_W-1:0]            rd_ts,
  output logic [AMP_W-1:0]           rd_amp,
  output logic [ROWS-1:0][COLS-1:0]  hit_map
);

  localparam int NPIX  = ROWS * COLS;
  localparam int IDX_W = $clog2(NPIX);

  logic [ROWS-1:0][COLS-1:0] hit_q, hit_d;
  logic [TS_W-1:0]           ts_mem  [NPIX];
  logic [AMP_W-1:0]          amp_mem [NPIX];
  logic [IDX_W-1:0]          cap_idx, rd_idx;
  logic                      same_px, cap_do;

  always_comb begin
    cap_idx = IDX_W'(cap_row) * IDX_W'(COLS) + IDX_W'(cap_col);
    rd_idx  = IDX_W'(rd_row)  * IDX_W'(COLS) + IDX_W'(rd_col);
    same_px = clr_en && (clr_row == cap_row) && (clr_col == cap_col);
    // A stored hit blocks new hits unless it is being read this cycle.
    cap_do  = cap_en && (!hit_q[cap_row][cap_col] || same_px);
    hit_d   = hit_q;
    if (clr_en) hit_d[clr_row][clr_col] = 1'b0;
    if (cap_do) hit_d[cap_row][cap_col] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit_d;
  end

  always_ff @(posedge clk) begin
    if (cap_do) begin
      ts_mem[cap_idx]  <= ts_code;
      amp_mem[cap_idx] <= cap_amp;
    end
  end

  assign rd_hit  = hit_q[rd_row][rd_col];
  assign rd_ts   = ts_mem[rd_idx];
  assign rd_amp  = amp_mem[rd_idx];
  assign hit_map = hit_q;

endmodule

// File: rtl/sparse_token_scan.sv
`timescale 1ns/1ps
module sparse_token_scan #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int RA_W = 6,
  parameter int CA_W = 6
) (
  input  logic [ROWS-1:0][COLS-1:0] hit_map,
  input  logic                      take_all,
  input  logic [RA_W-1:0]           start_row,
  input  logic [CA_W-1:0]           start_col,
  output logic                      found,
  output logic [RA_W-1:0]           sel_row,
  output logic [CA_W-1:0]           sel_col
);

  logic [COLS-1:0]           col_ge;
  logic [ROWS-1:0][COLS-1:0] cand;
  logic [ROWS-1:0]           row_any;
  logic [COLS-1:0]           sel_line;

  always_comb begin
    for (int c = 0; c < COLS; c++) col_ge[c] = (CA_W'(c) >= start_col);
  end

  // Per-row token path: rows before the token are bypassed, the token row
  // is masked below the token column, later rows are taken whole.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] elig;
    assign elig       = take_all ? {COLS{1'b1}} : hit_map[r];
    assign cand[r]    = (RA_W'(r) < start_row)  ? '0 :
                        (RA_W'(r) == start_row) ? (elig & col_ge) : elig;
    assign row_any[r] = |cand[r];
  end

  always_comb begin
    found   = |row_any;
    sel_row = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_any[r]) sel_row = RA_W'(r);
    end
    sel_line = cand[sel_row];
    sel_col  = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (sel_line[c]) sel_col = CA_W'(c);
    end
  end

endmodule

// File: rtl/sparse_out_reg.sv
`timescale 1ns/1ps
module sparse_out_reg #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);

  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (load)       valid_d = 1'b1;
    else if (ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= load_data;
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R5: a stalled record stays presented and unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

endmodule

// File: rtl/sparse_readout.sv
`timescale 1ns/1ps
module sparse_readout #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int TS_W  = 5,
  parameter int AMP_W = 8
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            stamp_clk,
  input  logic                                            hit_stb,
  input  logic [$clog2(ROWS)-1:0]                         hit_row,
  input  logic [$clog2(COLS)-1:0]                         hit_col,
  input  logic [AMP_W-1:0]                                hit_amp,
  input  logic [1:0]                                      rd_mode,
  input  logic                                            tok_inject,
  input  logic                                            rec_ready,
  output logic                                            rec_valid,
  output logic [$clog2(ROWS)+$clog2(COLS)+TS_W+AMP_W-1:0] rec_data,
  output logic                                            frame_end,
  output logic                                            busy
);
  import sparse_ro_pkg::*;

  localparam int RA_W  = $clog2(ROWS);
  localparam int CA_W  = $clog2(COLS);
  localparam int REC_W = RA_W + CA_W + TS_W + AMP_W;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // Token walker state.
  scan_st_e        st_q, st_d;
  rd_mode_e        mode_q, mode_d;
  logic [RA_W-1:0] row_q, row_d;
  logic [CA_W-1:0] col_q, col_d;
  logic            past_q, past_d;
  logic            eof_q, eof_d;

  logic [TS_W-1:0]           ts_code;
  logic [ROWS-1:0][COLS-1:0] hit_map;
  logic                      scan_found;
  logic [RA_W-1:0]           scan_row, pick_row;
  logic [CA_W-1:0]           scan_col, pick_col;
  logic                      pick_found, running, pix0, take_all;
  logic                      can_load, load, finish;
  logic                      rd_hit;
  logic [TS_W-1:0]           rd_ts;
  logic [AMP_W-1:0]          rd_amp;
  logic [REC_W-1:0]          rec_next;

  sparse_stamp_gen #(.TS_W(TS_W)) stamp_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .stamp_clk (stamp_clk),
    .ts_code   (ts_code)
  );

  sparse_pixel_store #(
    .ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .AMP_W(AMP_W), .RA_W(RA_W), .CA_W(CA_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cap_en  (hit_stb),
    .cap_row (hit_row),
    .cap_col (hit_col),
    .cap_amp (hit_amp),
    .ts_code (ts_code),
    .clr_en  (load),
    .clr_row (pick_row),
    .clr_col (pick_col),
    .rd_row  (pick_row),
    .rd_col  (pick_col),
    .rd_hit  (rd_hit),
    .rd_ts   (rd_ts),
    .rd_amp  (rd_amp),
    .hit_map (hit_map)
  );

  sparse_token_scan #(
    .ROWS(ROWS), .COLS(COLS), .RA_W(RA_W), .CA_W(CA_W)
  ) scan_i (
    .hit_map   (hit_map),
    .take_all  (take_all),
    .start_row (row_q),
    .start_col (col_q),
    .found     (scan_found),
    .sel_row   (scan_row),
    .sel_col   (scan_col)
  );

  sparse_out_reg #(.W(REC_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (load),
    .load_data (rec_next),
    .ready     (rec_ready),
    .valid     (rec_valid),
    .data      (rec_data)
  );

  // Token position and hand-off decision.
  always_comb begin
    running  = (st_q == SCAN_RUN);
    pix0     = (mode_q == RD_PIX0);
    take_all = (mode_q == RD_ALL);
    can_load = !rec_valid || rec_ready;
    if (pix0) begin
      pick_found = !past_q;
      pick_row   = '0;
      pick_col   = '0;
    end else begin
      pick_found = scan_found && !past_q;
      pick_row   = scan_row;
      pick_col   = scan_col;
    end
    load     = running && pick_found && can_load;
    finish   = running && !pick_found && can_load;
    rec_next = {pick_row, pick_col,
                rd_hit ? rd_ts  : {TS_W{1'b0}},
                rd_hit ? rd_amp : {AMP_W{1'b0}}};
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    row_d  = row_q;
    col_d  = col_q;
    past_d = past_q;
    eof_d  = 1'b0;
    if (!running) begin
      if (tok_inject) begin
        st_d   = SCAN_RUN;
        mode_d = rd_mode_e'(rd_mode);
        row_d  = '0;
        col_d  = '0;
        past_d = 1'b0;
      end
    end else if (load) begin
      if (pick_col == CA_W'(COLS - 1)) begin
        col_d = '0;
        if (pick_row == RA_W'(ROWS - 1)) past_d = 1'b1;
        else                             row_d  = pick_row + 1'b1;
      end else begin
        row_d = pick_row;
        col_d = pick_col + 1'b1;
      end
      if (pix0) past_d = 1'b1;
    end else if (finish) begin
      st_d  = SCAN_IDLE;
      eof_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q   <= SCAN_IDLE;
      mode_q <= RD_SPARSE;
      row_q  <= '0;
      col_q  <= '0;
      past_q <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      row_q  <= row_d;
      col_q  <= col_d;
      past_q <= past_d;
      eof_q  <= eof_d;
    end
  end

  assign busy      = running;
  assign frame_end = eof_q;

  // R5: a record is only loaded into a free or draining output slot
  assert_load_gate_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    load |-> (!rec_valid || rec_ready));

  // R4: the token never moves backwards in the scan order
  assert_scan_order_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (running && scan_found && !pix0) |-> ({scan_row, scan_col} >= {row_q, col_q}));

  // R7: end-of-frame follows a running frame and leaves the block idle
  assert_eof_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    frame_end |-> ($past(busy) && !busy));

  // R7: end-of-frame lasts one cycle
  assert_eof_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    frame_end |=> !frame_end);

endmodule

// File: tb/sparse_readout_tb_top.sv
`timescale 1ns/1ps
module sparse_readout_tb_top;

  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int NPIX = ROWS * COLS;
  localparam int NTBL = 9;

  // Stimulus table: {row, col, amp, stamp pulses before the hit}.
  // The repeated (5,9) entry must be ignored (R3); the pulses total 37 (wrap, R2).
  localparam logic [27:0] HIT_TBL [NTBL] = '{
    {6'd5,  6'd9,  8'h11, 8'd0},
    {6'd63, 6'd63, 8'hF0, 8'd3},
    {6'd0,  6'd0,  8'h01, 8'd5},
    {6'd5,  6'd2,  8'h22, 8'd7},
    {6'd5,  6'd9,  8'h99, 8'd1},
    {6'd40, 6'd0,  8'h3C, 8'd9},
    {6'd0,  6'd63, 8'hA5, 8'd6},
    {6'd63, 6'd0,  8'h5A, 8'd4},
    {6'd12, 6'd33, 8'hFF, 8'd2}
  };

  logic        clk, rst_n, stamp_clk, hit_stb, tok_inject, rec_ready;
  logic [5:0]  hit_row, hit_col;
  logic [7:0]  hit_amp;
  logic [1:0]  rd_mode;
  logic        rec_valid, frame_end, busy;
  logic [24:0] rec_data;

  sparse_readout #(.ROWS(ROWS), .COLS(COLS), .TS_W(5), .AMP_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .stamp_clk(stamp_clk), .hit_stb(hit_stb),
    .hit_row(hit_row), .hit_col(hit_col), .hit_amp(hit_amp), .rd_mode(rd_mode),
    .tok_inject(tok_inject), .rec_ready(rec_ready), .rec_valid(rec_valid),
    .rec_data(rec_data), .frame_end(frame_end), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int         n_chk, n_bad, stamp_cnt, wd_cyc;
  bit         mhit [NPIX];
  logic [4:0] mts  [NPIX];
  logic [7:0] mamp [NPIX];
  logic [7:0] lfsr;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below 150000", wd_cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [4:0] exp_code(int n);
    logic [4:0] b;
    b = 5'(n);
    return ~(b ^ (b >> 1));
  endfunction

  task automatic check_eq(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int count_hits();
    int n = 0;
    for (int i = 0; i < NPIX; i++) if (mhit[i]) n++;
    return n;
  endfunction

  task automatic stamp_pulse();
    @(negedge clk); stamp_clk = 1'b1;
    repeat (2) @(negedge clk);
    stamp_clk = 1'b0;
    repeat (3) @(negedge clk);
    stamp_cnt = (stamp_cnt + 1) % 32;
  endtask

  task automatic put_hit(int r, int c, logic [7:0] a);
    int idx = r * COLS + c;
    @(negedge clk);
    hit_stb = 1'b1; hit_row = 6'(r); hit_col = 6'(c); hit_amp = a;
    @(negedge clk);
    hit_stb = 1'b0;
    if (!mhit[idx]) begin
      mhit[idx] = 1'b1;
      mts[idx]  = exp_code(stamp_cnt);
      mamp[idx] = a;
    end
  endtask

  task automatic start_inject(int mode);
    @(negedge clk);
    rd_mode = 2'(mode); tok_inject = 1'b1;
    @(negedge clk);
    tok_inject = 1'b0;
  endtask

  // Collects one frame and compares every record with the model.
  task automatic collect(int mode, bit bp, bit poke, string req, int exp_n);
    int          mptr = 0;
    int          got = 0;
    int          idx;
    bit          held = 0;
    bit          done = 0;
    bit          pix0_done = 0;
    bit          rdy;
    logic [24:0] hd, exp_rec;
    for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
      @(negedge clk);
      hit_stb    = 1'b0;
      tok_inject = (poke && cyc == 50);
      if (held) begin
        check_eq("R5", "stalled valid", rec_valid, 1);
        check_eq("R5", "stalled data", rec_data, hd);
      end
      if (frame_end) begin
        done = 1;
      end else if (rec_valid) begin
        rdy  = bp ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rec_ready = rdy;
        if (rdy) begin
          held = 0;
          idx  = -1;
          if (mode == 1) idx = mptr;
          else if (mode == 2) idx = pix0_done ? -1 : 0;
          else begin
            for (int i = NPIX - 1; i >= mptr; i--) if (mhit[i]) idx = i;
          end
          if (idx < 0 || idx >= NPIX) begin
            n_chk++; n_bad++;
            $display("FAIL %s unexpected record: actual %0h expected none", req, rec_data);
          end else begin
            exp_rec = {6'(idx / COLS), 6'(idx % COLS),
                       mhit[idx] ? mts[idx] : 5'd0, mhit[idx] ? mamp[idx] : 8'd0};
            check_eq(req, "record", rec_data, exp_rec);
            mhit[idx] = 1'b0;
            mptr = idx + 1;
            pix0_done = 1;
          end
          got++;
        end else begin
          held = 1;
          hd   = rec_data;
        end
      end else begin
        rec_ready = bp ? 1'b0 : 1'b1;
        held = 0;
      end
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s frame end: actual 0 expected 1", req);
    end
    check_eq(req, "record count", got, exp_n);
    check_eq("R7", "busy at frame end", busy, 0);
    @(negedge clk);
    check_eq("R7", "frame_end one cycle", frame_end, 0);
    check_eq("R11", "no restarted frame", busy, 0);
  endtask

  initial begin
    int idx;
    n_chk = 0; n_bad = 0; stamp_cnt = 0; wd_cyc = 0; lfsr = 8'hA5;
    rst_n = 1'b0; stamp_clk = 1'b0; hit_stb = 1'b0; tok_inject = 1'b0;
    rec_ready = 1'b0; hit_row = '0; hit_col = '0; hit_amp = '0; rd_mode = '0;
    for (int i = 0; i < NPIX; i++) begin mhit[i] = 0; mts[i] = '0; mamp[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports
    check_eq("R1", "rec_valid", rec_valid, 0);
    check_eq("R1", "frame_end", frame_end, 0);
    check_eq("R1", "busy", busy, 0);

    // R6: empty matrix, the token runs straight to the end
    start_inject(0);
    check_eq("R6", "busy after inject", busy, 1);
    check_eq("R6", "frame_end early", frame_end, 0);
    check_eq("R6", "rec_valid", rec_valid, 0);
    @(negedge clk);
    check_eq("R6", "frame_end", frame_end, 1);
    check_eq("R7", "busy falls with frame_end", busy, 0);
    @(negedge clk);
    check_eq("R7", "frame_end pulse", frame_end, 0);

    // R2/R3/R4: table walk; first entry carries code 5'b11111 (R1)
    for (int t = 0; t < NTBL; t++) begin
      for (int p = 0; p < int'(HIT_TBL[t][7:0]); p++) stamp_pulse();
      put_hit(int'(HIT_TBL[t][27:22]), int'(HIT_TBL[t][21:16]), HIT_TBL[t][15:8]);
    end
    check_eq("R1", "first code in model", mts[5 * COLS + 9], 5'b11111);
    start_inject(0);
    collect(0, 1, 0, "R4", count_hits());

    // R4: hits were cleared, alternate sparse code yields nothing
    start_inject(3);
    collect(3, 0, 0, "R4", 0);

    // R9: pixel (0,0) only, empty then holding a hit; other hits kept
    put_hit(3, 3, 8'h33);
    start_inject(2);
    collect(2, 0, 0, "R9", 1);
    start_inject(0);
    collect(0, 0, 0, "R9", 1);
    put_hit(0, 0, 8'h5E);
    start_inject(2);
    collect(2, 1, 0, "R9", 1);

    // R8/R11: whole matrix, with an injection attempt mid-frame
    stamp_pulse();
    put_hit(10, 10, 8'hC3);
    put_hit(63, 62, 8'h07);
    start_inject(1);
    collect(1, 0, 1, "R8", NPIX);
    start_inject(0);
    collect(0, 0, 0, "R8", 0);

    // R10: strobe to the pixel in the cycle its record is loaded
    put_hit(7, 7, 8'h44);
    @(negedge clk);
    rd_mode = 2'd0; tok_inject = 1'b1;
    @(negedge clk);
    tok_inject = 1'b0;
    hit_stb = 1'b1; hit_row = 6'd7; hit_col = 6'd7; hit_amp = 8'h77;
    collect(0, 0, 0, "R10", 1);
    idx = 7 * COLS + 7;
    mhit[idx] = 1'b1; mts[idx] = exp_code(stamp_cnt); mamp[idx] = 8'h77;
    start_inject(0);
    collect(0, 0, 0, "R10", 1);

    summary();
    $finish;
  end

endmodule